// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two component predictors side by side and letting a per-branch arbiter pick between them. One component keeps a shift register of recent branch outcomes across the whole program. That register is the only index into a table of 2-bit counters. The other component is two-level. A table of per-branch outcome histories, selected by low PC bits, picks one of a set of 3-bit counters. A third table of 2-bit arbiter counters, also selected by PC, decides for each branch which component to trust.

The fetch side puts a PC on the predict port. In the same cycle it reads back the final direction, both component opinions and the arbiter's choice. The lookup is combinational and reads the state as it stood before any update at the coming clock edge. When the branch resolves, the back end presents the PC, the real outcome and the two component opinions recorded at fetch. At the next edge the block trains both components and the arbiter, then shifts the outcome into the global history and into the branch's local history.

Top module: `tournament_bp`

## Requirements
- R1: After reset every PC reads back global opinion 0, local opinion 0, arbiter choice 0 (global) and final direction 0 (not taken). This is because the global counters reset to 1, the local counters to 3, the arbiter counters to 1 and all histories to zero.
- R2: The final direction equals the local opinion when the arbiter choice is 1, and the global opinion when it is 0.
- R3: The global opinion is bit 1 of the 2-bit counter selected by the 12-bit global history alone. The PC plays no part. On a valid update that counter steps up by one on taken and down by one on not taken, saturating at 0 and 3.
- R4: On a valid update the global history shifts left by one. The new outcome enters bit 0 (1 = taken), so bit i holds the outcome of the (i+1)-th most recent branch.
- R5: Local histories are 10 bits wide, one for each of 1024 entries selected by PC bits [11:2]. On a valid update the selected history shifts left with the outcome entering bit 0.
- R6: The local opinion is 1 when the 3-bit counter selected by the branch's local history is 4 or more. A valid update steps that counter up on taken and down on not taken, saturating at 0 and 7.
- R7: On a valid update the arbiter counter moves one step toward the local side (up) when only the local opinion matched the outcome, and toward the global side (down) when only the global opinion matched. It stays put when both opinions are equal.
- R8: Arbiter counters saturate at 0 and 3, and values 2 and 3 choose local. So from a weak state a single disagreement in one direction flips the choice, and from a strong state two are needed.
- R9: With the update valid low, the update fields have no effect. Predictions for any PC stay as they were, and a prediction always reflects the state before the same cycle's update.
- R10: The arbiter counter is selected by PC bits [13:2]. Branches that share bits [11:2] but differ in bits [13:12] share a local history but train separate arbiter counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | 32 | PC looked up for prediction |
| pred_taken | output | 1 | Final predicted direction, 1 = taken |
| pred_glob | output | 1 | Opinion of the global-history component |
| pred_loc | output | 1 | Opinion of the local-history component |
| pred_sel_local | output | 1 | Arbiter choice, 1 = local component used |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_glob_pred | input | 1 | Global opinion recorded at fetch |
| upd_loc_pred | input | 1 | Local opinion recorded at fetch |

## Verification
The hardest state to reach is an arbiter counter that actually moves. The two components must disagree on a branch, and that happens only after one of them has trained differently from the other. From reset both say not taken. The stimulus therefore runs loop-shaped and alternating outcome streams until the local counters saturate and the global table learns, then mixes a small pool of PCs with random outcomes. That pool includes PCs aliasing in the local table but not in the arbiter table, so switches in both directions and both saturation ends appear. A bench model built from the requirements predicts every opinion.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    ARB_GLOB_STRONG = 2'd0,
    ARB_GLOB_WEAK   = 2'd1,
    ARB_LOC_WEAK    = 2'd2,
    ARB_LOC_STRONG  = 2'd3
  } arb_state_e;

  localparam int unsigned ARB_W = 2;

endpackage

// File: rtl/tp_sat_step.sv
module tp_sat_step #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] MINV = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt = cur;
    if (up) begin
      if (cur != MAXV) nxt = cur + ONE;
    end else begin
      if (cur != MINV) nxt = cur - ONE;
    end
  end
endmodule

// File: rtl/tp_global_pred.sv
module tp_global_pred #(
  parameter int unsigned HIST_W = 12,
  parameter int unsigned CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic              opinion,
  output logic [HIST_W-1:0] hist_o
);
  localparam int unsigned DEPTH = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_RST = {1'b0, {(CTR_W-1){1'b1}}};

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [CTR_W-1:0]  tbl_q [DEPTH];
  logic [CTR_W-1:0]  cur_ctr, wr_ctr;

  assign cur_ctr = tbl_q[hist_q];
  assign opinion = cur_ctr[CTR_W-1];
  assign hist_o  = hist_q;

  tp_sat_step #(.W(CTR_W)) u_step (
    .cur (cur_ctr),
    .up  (upd_taken),
    .nxt (wr_ctr)
  );

  always_comb begin
    hist_d = hist_q;
    if (upd_en) hist_d = {hist_q[HIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_RST;
    end else if (upd_en) begin
      tbl_q[hist_q] <= wr_ctr;
    end
  end
endmodule

// File: rtl/tp_local_pred.sv
module tp_local_pred #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10,
  parameter int unsigned CTR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             opinion,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int unsigned HT_DEPTH  = 1 << IDX_W;
  localparam int unsigned CT_DEPTH  = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_RST = {1'b0, {(CTR_W-1){1'b1}}};

  logic [HIST_W-1:0] hist_q [HT_DEPTH];
  logic [CTR_W-1:0]  ctr_q  [CT_DEPTH];

  logic [HIST_W-1:0] rd_hist, up_hist, up_hist_nxt;
  logic [CTR_W-1:0]  rd_ctr, up_ctr, up_ctr_nxt;

  assign rd_hist = hist_q[rd_idx];
  assign rd_ctr  = ctr_q[rd_hist];
  assign opinion = rd_ctr[CTR_W-1];

  assign up_hist = hist_q[upd_idx];
  assign up_ctr  = ctr_q[up_hist];

  tp_sat_step #(.W(CTR_W)) u_step (
    .cur (up_ctr),
    .up  (upd_taken),
    .nxt (up_ctr_nxt)
  );

  always_comb begin
    up_hist_nxt = {up_hist[HIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HT_DEPTH; i++) hist_q[i] <= '0;
    end else if (upd_en) begin
      hist_q[upd_idx] <= up_hist_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CT_DEPTH; i++) ctr_q[i] <= CTR_RST;
    end else if (upd_en) begin
      ctr_q[up_hist] <= up_ctr_nxt;
    end
  end
endmodule

// File: rtl/tp_arbiter.sv
module tp_arbiter #(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             use_local,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  logic             upd_glob,
  input  logic             upd_loc
);
  import tp_pkg::*;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ARB_W-1:0] arb_q [DEPTH];
  logic [ARB_W-1:0] cur_arb, nxt_arb;
  logic             disagree, loc_right, wr_en;
  arb_state_e       rd_state;

  assign rd_state  = arb_state_e'(arb_q[rd_idx]);
  assign use_local = (rd_state == ARB_LOC_WEAK) || (rd_state == ARB_LOC_STRONG);

  assign cur_arb   = arb_q[upd_idx];
  assign disagree  = upd_glob ^ upd_loc;
  assign loc_right = (upd_loc == upd_taken);
  assign wr_en     = upd_valid && disagree;

  tp_sat_step #(.W(ARB_W)) u_step (
    .cur (cur_arb),
    .up  (loc_right),
    .nxt (nxt_arb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arb_q[i] <= ARB_GLOB_WEAK;
    end else if (wr_en) begin
      arb_q[upd_idx] <= nxt_arb;
    end
  end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned ALIGN      = 2,
  parameter int unsigned GHIST_W    = 12,
  parameter int unsigned GCTR_W     = 2,
  parameter int unsigned LIDX_W     = 10,
  parameter int unsigned LHIST_W    = 10,
  parameter int unsigned LCTR_W     = 3,
  parameter int unsigned ARB_IDX_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_glob,
  output logic            pred_loc,
  output logic            pred_sel_local,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_glob_pred,
  input  logic            upd_loc_pred
);
  localparam int unsigned IDX_TOP = ALIGN + ARB_IDX_W;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [LIDX_W-1:0]    rd_lidx, up_lidx;
  logic [ARB_IDX_W-1:0] rd_aidx, up_aidx;
  logic [GHIST_W-1:0]   ghist_w;
  logic                 unused_pc_bits;

  assign rd_lidx = pred_pc[ALIGN +: LIDX_W];
  assign up_lidx = upd_pc[ALIGN +: LIDX_W];
  assign rd_aidx = pred_pc[ALIGN +: ARB_IDX_W];
  assign up_aidx = upd_pc[ALIGN +: ARB_IDX_W];
  assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_TOP], pred_pc[ALIGN-1:0],
                            upd_pc[PC_W-1:IDX_TOP], upd_pc[ALIGN-1:0]};

  tp_global_pred #(.HIST_W(GHIST_W), .CTR_W(GCTR_W)) u_glob (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd_en    (upd_valid),
    .upd_taken (upd_taken),
    .opinion   (pred_glob),
    .hist_o    (ghist_w)
  );

  tp_local_pred #(.IDX_W(LIDX_W), .HIST_W(LHIST_W), .CTR_W(LCTR_W)) u_loc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_idx    (rd_lidx),
    .opinion   (pred_loc),
    .upd_en    (upd_valid),
    .upd_idx   (up_lidx),
    .upd_taken (upd_taken)
  );

  tp_arbiter #(.IDX_W(ARB_IDX_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_idx    (rd_aidx),
    .use_local (pred_sel_local),
    .upd_valid (upd_valid),
    .upd_idx   (up_aidx),
    .upd_taken (upd_taken),
    .upd_glob  (upd_glob_pred),
    .upd_loc   (upd_loc_pred)
  );

  assign pred_taken = pred_sel_local ? pred_loc : pred_glob;
endmodule

// File: rtl/tournament_bp_checker.sv
module tournament_bp_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned GHIST_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    pred_pc,
  input logic               pred_taken,
  input logic               pred_glob,
  input logic               pred_loc,
  input logic               pred_sel_local,
  input logic               upd_valid,
  input logic [PC_W-1:0]    upd_pc,
  input logic               upd_taken,
  input logic               upd_glob_pred,
  input logic               upd_loc_pred,
  input logic [GHIST_W-1:0] ghist
);
  AST_AGREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_glob == pred_loc) |-> (pred_taken == pred_glob)); // R2

  AST_SEL_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_sel_local && (pred_glob != pred_loc)) |-> (pred_taken == pred_glob)); // R2

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ((ghist[0] == $past(upd_taken)) &&
                   (ghist[GHIST_W-1:1] == $past(ghist[GHIST_W-2:0])))); // R4

  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ((pred_pc != $past(pred_pc)) ||
                    ($stable(pred_glob) && $stable(pred_loc) && $stable(pred_sel_local)))); // R9

  AST_ARB_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_glob_pred == upd_loc_pred) && (pred_pc == upd_pc))
      |=> ((pred_pc != $past(pred_pc)) || $stable(pred_sel_local))); // R7
endmodule

bind tournament_bp tournament_bp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .pred_pc        (pred_pc),
  .pred_taken     (pred_taken),
  .pred_glob      (pred_glob),
  .pred_loc       (pred_loc),
  .pred_sel_local (pred_sel_local),
  .upd_valid      (upd_valid),
  .upd_pc         (upd_pc),
  .upd_taken      (upd_taken),
  .upd_glob_pred  (upd_glob_pred),
  .upd_loc_pred   (upd_loc_pred),
  .ghist          (ghist_w)
);

// File: tb/tournament_bp_tb_top.sv
`timescale 1ns/1ps
module tournament_bp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_glob, pred_loc, pred_sel_local;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0, upd_glob_pred = 1'b0, upd_loc_pred = 1'b0;

  always #5 clk = ~clk;

  tournament_bp dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_glob(pred_glob), .pred_loc(pred_loc), .pred_sel_local(pred_sel_local),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_glob_pred(upd_glob_pred), .upd_loc_pred(upd_loc_pred)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state, built from the requirements
  int gtab [4096];
  int arb  [4096];
  int lhist[1024];
  int lctr [1024];
  int ghr;

  typedef struct {
    logic [31:0] pc;
    bit g, l, s, t;
    int ph;
  } item_t;
  item_t sb_q[$];

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin gtab[i] = 1; arb[i] = 1; end
    for (int i = 0; i < 1024; i++) begin lhist[i] = 0; lctr[i] = 3; end
    ghr = 0;
  endtask

  task automatic chk(bit ok, string what, int ph, logic [31:0] pc, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s phase %0d pc=%h actual=%0d expected=%0d", what, ph, pc, act, exp);
    end
  endtask

  // driver: computes expectation, drives both ports, pushes to scoreboard
  task automatic branch(logic [31:0] pc, bit taken, bit do_upd, int ph);
    item_t it;
    int li, ci, h;
    @(negedge clk);
    li = int'(pc[11:2]);            // R5 local history index
    ci = int'(pc[13:2]);            // R10 arbiter index
    h  = lhist[li];
    it.pc = pc;
    it.g  = (gtab[ghr] >= 2);       // R3
    it.l  = (lctr[h] >= 4);         // R6
    it.s  = (arb[ci] >= 2);         // R8
    it.t  = it.s ? it.l : it.g;     // R2
    it.ph = ph;
    sb_q.push_back(it);
    pred_pc       = pc;
    upd_valid     = do_upd;
    upd_pc        = do_upd ? pc : $urandom();
    upd_taken     = taken;
    upd_glob_pred = do_upd ? it.g : 1'($urandom());
    upd_loc_pred  = do_upd ? it.l : 1'($urandom());
    if (do_upd) begin
      if (taken) begin
        if (gtab[ghr] < 3) gtab[ghr]++;
        if (lctr[h] < 7) lctr[h]++;
      end else begin
        if (gtab[ghr] > 0) gtab[ghr]--;
        if (lctr[h] > 0) lctr[h]--;
      end
      if (it.g != it.l) begin   // R7
        if (it.l == taken) begin if (arb[ci] < 3) arb[ci]++; end
        else begin if (arb[ci] > 0) arb[ci]--; end
      end
      ghr = ((ghr << 1) | int'(taken)) & 12'hFFF;         // R4
      lhist[li] = ((h << 1) | int'(taken)) & 10'h3FF;     // R5
    end
  endtask

  // monitor: compares each pushed item away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk(pred_glob == it.g, "R3 global opinion", it.ph, it.pc, int'(pred_glob), int'(it.g));
        chk(pred_loc == it.l, "R6 local opinion", it.ph, it.pc, int'(pred_loc), int'(it.l));
        chk(pred_sel_local == it.s, "R8 arbiter choice", it.ph, it.pc, int'(pred_sel_local), int'(it.s));
        chk(pred_taken == it.t, "R2 final direction", it.ph, it.pc, int'(pred_taken), int'(it.t));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    pool[0] = 32'h0000_1004; pool[1] = 32'h0000_2004;  // R10: same [11:2], other [13:12]
    pool[2] = 32'h0000_0120; pool[3] = 32'h0000_3120;
    pool[4] = 32'h0000_0408; pool[5] = 32'h0000_0ffc;
    pool[6] = 32'h0000_0040; pool[7] = 32'h0000_0844;
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state seen on several PCs, no training
    branch(32'h0, 1'b0, 1'b0, 1);
    branch(32'h0000_0100, 1'b1, 1'b0, 1);
    branch(32'hffff_fffc, 1'b1, 1'b0, 1);
    branch(32'h0000_3ffc, 1'b0, 1'b0, 1);

    // R5 R6: loop-shaped branch, seven taken then exit
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 7; k++) branch(32'h0000_0100, 1'b1, 1'b1, 2);
      branch(32'h0000_0100, 1'b0, 1'b1, 2);
    end

    // R3 R4: alternating branch trains global table by history
    for (int k = 0; k < 40; k++) branch(32'h0000_0200, k[0], 1'b1, 3);

    // R6 saturation: long taken run then long not-taken run
    for (int k = 0; k < 20; k++) branch(32'h0000_0300, 1'b1, 1'b1, 4);
    for (int k = 0; k < 20; k++) branch(32'h0000_0300, 1'b0, 1'b1, 4);

    // R7 R8 R10: pool of PCs with random outcomes, components disagree
    for (int k = 0; k < 400; k++) begin
      int p;
      p = int'($urandom_range(0, 7));
      branch(pool[p], 1'($urandom()), 1'b1, 5);
    end

    // R9: update fields toggled with valid low, then predictions rechecked
    for (int k = 0; k < 30; k++) branch(pool[k % 8], 1'($urandom()), 1'b0, 6);
    for (int k = 0; k < 8; k++) branch(pool[k], 1'b0, 1'b0, 6);

    // R7 R8: biased mix after idle stretch
    for (int k = 0; k < 120; k++) begin
      int p;
      p = int'($urandom_range(0, 3));
      branch(pool[p], ($urandom_range(0, 3) != 0), 1'b1, 7);
    end

    @(negedge clk);
    upd_valid = 1'b0;
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule